// File: doc/BRIEF.md
# Microprogram next-address sequencer

This block chooses which control-store word a microprogrammed controller runs next. Every microinstruction carries the address of its successor. The sequencer takes that address and changes it in two ways only. A conditional branch ORs a datapath flag into the top address bit. A dispatch ORs the fetched instruction opcode into the low address bits. Because of this, a two-way branch lands on one of two words placed 256 locations apart. An opcode dispatch through a successor field of zero reaches the routine whose address equals the opcode, in a single cycle.

The block holds the current microinstruction in a register and the micro-address in a second register. Both load on the same clock edge: the address register takes the newly computed address, and the microinstruction register takes the store word at that address. The control store is a small array written through a simple load port, which a bench uses to place a test program. The negative and zero flags come in already latched from the datapath, and they belong to the ALU result of the microinstruction now in the register.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `uaddr` is 0 and `uword` holds the store word at address 0.
- R2: With a jump field of 000, the next `uaddr` equals the 9-bit successor field of the current word exactly, whatever the flags and the opcode are.
- R3: Bit 8 of the next `uaddr` is successor bit 8 ORed with (zero-branch bit AND `flag_z`) ORed with (negative-branch bit AND `flag_n`). Bits 7..0 come through unchanged whenever the dispatch bit is clear.
- R4: When the dispatch bit is set, bits 7..0 of the next `uaddr` are successor bits 7..0 ORed with `opcode`.
- R5: A dispatch whose successor bits 7..0 are zero sends `uaddr` bits 7..0 to the opcode value itself.
- R6: The negative-branch and zero-branch bits may both be set, and then either flag alone raises bit 8.
- R7: A flag whose branch bit is clear has no effect on `uaddr`, and `opcode` has no effect while the dispatch bit is clear.
- R8: On each clock edge out of reset, `uword` loads the store word at the new `uaddr`.
- R9: A store word is 12 bits. Bits 11..3 are the successor field. Bits 2..0 are the jump field: bit 2 is dispatch, bit 1 is negative-branch, bit 0 is zero-branch. A write with `cs_we` high stores `cs_wdata` at `cs_waddr` on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the address asynchronously |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 9 | Control-store write address |
| cs_wdata | input | 12 | Control-store write word |
| flag_n | input | 1 | Latched negative flag of the current ALU result |
| flag_z | input | 1 | Latched zero flag of the current ALU result |
| opcode | input | 8 | Fetched instruction byte used for dispatch |
| uaddr | output | 9 | Current micro-address |
| uword | output | 12 | Current microinstruction |

## Verification
The bench sweeps all eight jump-field values against every pair of flag values, several opcodes and several successor fields, including fields of zero and of 0x100. The goal is to catch a design that selects between targets instead of ORing into them, or one that replaces the low bits with the opcode instead of merging them. It also covers the case where the two branch bits share one flag, or where only one of them is honoured: a flag whose own branch bit is clear must leave bit 8 alone. Each case then takes one more plain step, so a microinstruction register that lags one cycle behind the address shows up as a wrong word or a wrong successor.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int JUMP_W  = 3;
  localparam int JB_DISP = 2;
  localparam int JB_NEG  = 1;
  localparam int JB_ZERO = 0;
  typedef logic [JUMP_W-1:0] jump_t;
endpackage

// File: rtl/useq_addr.sv
module useq_addr
  import useq_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0] succ,
  input  jump_t         jump,
  input  logic          flag_n,
  input  logic          flag_z,
  input  logic [AW-2:0] opcode,
  output logic [AW-1:0] addr_d,
  output logic          hi_raise,
  output logic          dispatch
);
  localparam int OW = AW - 1;

  function automatic logic flag_hit(jump_t j, logic n, logic z);
    return (j[JB_ZERO] & z) | (j[JB_NEG] & n);
  endfunction

  function automatic logic [OW-1:0] merge_low(logic [OW-1:0] base, logic sel,
                                              logic [OW-1:0] op);
    return sel ? (base | op) : base;
  endfunction

  assign hi_raise = flag_hit(jump, flag_n, flag_z);
  assign dispatch = jump[JB_DISP];

  always_comb begin
    addr_d[AW-1]   = succ[AW-1] | hi_raise;
    addr_d[OW-1:0] = merge_low(succ[OW-1:0], dispatch, opcode);
  end
endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 9,
  parameter int WW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_upc.sv
module useq_upc #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_we,
  input  logic [AW-1:0]        cs_waddr,
  input  logic [AW+JUMP_W-1:0] cs_wdata,
  input  logic                 flag_n,
  input  logic                 flag_z,
  input  logic [AW-2:0]        opcode,
  output logic [AW-1:0]        uaddr,
  output logic [AW+JUMP_W-1:0] uword
);
  localparam int WW = AW + JUMP_W;

  logic [AW-1:0] succ;
  jump_t         jump;
  logic [AW-1:0] addr_d;
  logic [AW-1:0] rd_addr;
  logic          hi_raise;
  logic          dispatch;

  assign succ    = uword[WW-1:JUMP_W];
  assign jump    = uword[JUMP_W-1:0];
  assign rd_addr = rst_n ? addr_d : '0;

  useq_addr #(.AW(AW)) u_addr (
    .succ(succ), .jump(jump), .flag_n(flag_n), .flag_z(flag_z),
    .opcode(opcode), .addr_d(addr_d), .hi_raise(hi_raise), .dispatch(dispatch)
  );

  useq_upc #(.AW(AW)) u_upc (
    .clk(clk), .rst_n(rst_n), .d(addr_d), .q(uaddr)
  );

  useq_store #(.AW(AW), .WW(WW)) u_store (
    .clk(clk), .we(cs_we), .waddr(cs_waddr), .wdata(cs_wdata),
    .raddr(rd_addr), .rdata(uword)
  );

  // R2: a plain word hands its successor field straight to the address
  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (jump == '0) |=> (uaddr == $past(succ)));

  // R3: low bits pass through untouched when no dispatch is requested
  p_low_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dispatch |=> (uaddr[AW-2:0] == $past(succ[AW-2:0])));

  // R6: any enabled flag that is set forces the top bit
  p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_raise |=> uaddr[AW-1]);

  // R7: with no enabled flag set, the top bit follows the successor field
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_raise |=> (uaddr[AW-1] == $past(succ[AW-1])));

  // R4: every opcode bit shows up in the dispatched address
  p_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> ((uaddr[AW-2:0] & $past(opcode)) == $past(opcode)));
endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int WW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_we;
  logic [AW-1:0] cs_waddr;
  logic [WW-1:0] cs_wdata;
  logic          flag_n;
  logic          flag_z;
  logic [AW-2:0] opcode;
  logic [AW-1:0] uaddr;
  logic [WW-1:0] uword;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
    .cs_wdata(cs_wdata), .flag_n(flag_n), .flag_z(flag_z), .opcode(opcode),
    .uaddr(uaddr), .uword(uword)
  );

  // background program: address a holds successor a^0x0A5 and a zero jump field (R9 layout)
  function automatic logic [WW-1:0] fill(int a);
    logic [8:0] s;
    s = 9'(a) ^ 9'h0A5;
    return {s, 3'b000};
  endfunction

  function automatic logic [8:0] expect_addr(logic [8:0] nx, logic [2:0] j,
                                             logic n, logic z, logic [7:0] m);
    int v;
    v = int'(nx);
    if (j[2]) v = (v & 256) + (int'(nx[7:0]) | int'(m));
    if ((j[0] && z) || (j[1] && n)) v = v | 256;
    return 9'(v);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_case(logic [8:0] nx, logic [2:0] j, logic n, logic z,
                          logic [7:0] m);
    logic [WW-1:0] word;
    logic [8:0] e;
    logic [8:0] e2;
    string tag;
    word = {nx, j};
    @(negedge clk);
    rst_n = 1'b0; cs_we = 1'b1; cs_waddr = '0; cs_wdata = word;
    flag_n = n; flag_z = z; opcode = m;
    @(negedge clk);
    cs_we = 1'b0;
    @(negedge clk);
    check("R1 reset address", 32'(uaddr), 32'd0);
    check("R9 word at 0", 32'(uword), 32'(word));
    rst_n = 1'b1;
    @(negedge clk);
    e = expect_addr(nx, j, n, z, m);
    if (j[2] && nx[7:0] == 8'h00)           tag = "R5 zero-field dispatch";
    else if (j[1:0] == 2'b11)               tag = "R6 both branch bits";
    else if (j[2])                          tag = "R4 dispatch merge";
    else if (j[1:0] != 2'b00)               tag = "R3 flag into top bit";
    else if (n || z || m != 0)              tag = "R7 ignored inputs";
    else                                    tag = "R2 plain successor";
    check(tag, 32'(uaddr), 32'(e));
    check("R8 word follows address", 32'(uword), 32'((e == 0) ? word : fill(int'(e))));
    if (e != 0) begin
      @(negedge clk);
      e2 = e ^ 9'h0A5;
      check("R2 chained successor", 32'(uaddr), 32'(e2));
      check("R8 chained word", 32'(uword), 32'((e2 == 0) ? word : fill(int'(e2))));
    end
  endtask

  initial begin
    logic [8:0] nxs [5];
    logic [7:0] ops [4];
    nxs = '{9'h000, 9'h100, 9'h0A3, 9'h1FF, 9'h055};
    ops = '{8'h00, 8'hFF, 8'h5A, 8'h81};
    rst_n = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
    flag_n = 1'b0; flag_z = 1'b0; opcode = '0;
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      cs_we = 1'b1; cs_waddr = 9'(a); cs_wdata = fill(a);
    end
    @(negedge clk);
    cs_we = 1'b0;
    @(negedge clk);
    check("R1 initial reset address", 32'(uaddr), 32'd0);
    check("R1 initial word at 0", 32'(uword), 32'(fill(0)));
    for (int j = 0; j < 8; j++)
      for (int f = 0; f < 4; f++)
        for (int mi = 0; mi < 4; mi++)
          for (int ni = 0; ni < 5; ni++)
            run_case(nxs[ni], 3'(j), f[1], f[0], ops[mi]);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule